// File: doc/BRIEF.md
# Prefix Rule Tree Codec

This block turns a ternary prefix rule into a compact tree code word and turns that code word back into the span of table addresses the rule covers. A rule arrives as two W-bit words: a data word and a care mask. The encoder produces a (W+1)-bit node number in a heap-numbered binary tree. The root is 1. A node's left child is twice its value, and its right child is twice its value plus one. Because of this numbering, the number of leading zero bits in a code equals the number of don't-care bits in the rule.

The decoder expands the freshly encoded code word into the lowest and highest address the rule touches. The block also has a separate relation checker. It compares two code words given at its inputs and reports whether the first one lies on the tree path above the second. An update scheduler uses this to skip a rule whose address span is already covered by another rule in the same batch. A mask whose care bits do not form a single run starting at the MSB is flagged as an error, and the block produces no code for it.

All results are registered together, one clock after a valid input.

Top module: `prefix_tree_codec`

## Requirements
- R1: A mask bit of 1 marks a care bit. A legal mask has k care bits packed at the MSB end. For such a mask, out_code equals (1 << k) OR (in_data >> (W-k)), in a W+1 bit field.
- R2: Data bits at don't-care positions (mask bit 0) have no effect on any output.
- R3: A mask whose care bits are not one run starting at the MSB sets out_err to 1 and drives out_code, out_lo and out_hi to zero. A legal mask gives out_err 0.
- R4: For a legal rule, out_lo is the data word with its don't-care bits cleared, and out_hi is the data word with its don't-care bits set. An all-care mask gives out_lo = out_hi = in_data. An all-don't-care mask gives code 1 and the span 0 to 2^W-1.
- R5: For a legal rule, the highest set bit of out_code is at index k, the number of care bits. out_code is never zero.
- R6: out_is_anc is 1 when both anc_code and desc_code are nonzero and repeatedly halving desc_code (zero or more times) reaches anc_code. A code counts as its own ancestor. Otherwise out_is_anc is 0, including whenever either code is zero.
- R7: Outputs update one clock after a cycle with in_valid high, and out_valid is then 1. After a cycle with in_valid low, out_valid is 0 and every data output keeps its value.
- R8: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input words are valid this cycle |
| in_data | input | W | Rule data word |
| in_mask | input | W | Rule care mask, 1 = care |
| anc_code | input | W+1 | Candidate ancestor code for the relation check |
| desc_code | input | W+1 | Candidate descendant code for the relation check |
| out_valid | output | 1 | Registered results are fresh |
| out_err | output | 1 | Mask was not a prefix mask |
| out_code | output | W+1 | Tree code word of the rule |
| out_lo | output | W | First address covered by the rule |
| out_hi | output | W | Last address covered by the rule |
| out_is_anc | output | 1 | anc_code is an ancestor of desc_code |

## Verification
The bench builds the block with the default W = 8. At this size the input space is small enough to cover completely where it matters. The bench applies every one of the 511 legal rules, each with scrambled don't-care data. It applies all 256 masks to find every illegal pattern. It pairs every code of depth four or less, in both argument positions, with every possible code. Expected codes, spans and ancestry are computed in the bench by bit-serial tree walking and by halving, not by shifting the way the design does.

// File: rtl/prefix_tree_codec.sv
module prefix_tree_codec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] in_mask,
  input  logic [W:0]   anc_code,
  input  logic [W:0]   desc_code,
  output logic         out_valid,
  output logic         out_err,
  output logic [W:0]   out_code,
  output logic [W-1:0] out_lo,
  output logic [W-1:0] out_hi,
  output logic         out_is_anc
);

  localparam int CW = W + 1;
  localparam int DW = $clog2(W + 1);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  function automatic logic [DW-1:0] depth_of(input logic [CW-1:0] c);
    depth_of = '0;
    for (int i = 0; i < CW; i++)
      if (c[i]) depth_of = DW'(i);
  endfunction

  logic [DW-1:0] care_cnt;
  always_comb begin
    care_cnt = '0;
    for (int i = 0; i < W; i++)
      care_cnt = care_cnt + DW'(in_mask[i]);
  end

  wire mask_ok = (in_mask == ~(ONES >> care_cnt));

  logic [CW-1:0] enc_code;
  assign enc_code = mask_ok
    ? ((CW'(1) << care_cnt) | CW'(in_data >> (W - int'(care_cnt))))
    : '0;

  logic [DW-1:0] enc_depth;
  logic [CW-1:0] enc_val;
  logic [W-1:0]  dec_lo, dec_hi;
  assign enc_depth = depth_of(enc_code);
  assign enc_val   = enc_code & ~(CW'(1) << enc_depth);
  assign dec_lo    = mask_ok ? W'(enc_val << (W - int'(enc_depth))) : '0;
  assign dec_hi    = mask_ok ? (dec_lo | (ONES >> enc_depth)) : '0;

  logic [DW-1:0] da, db;
  logic          anc_hit;
  assign da = depth_of(anc_code);
  assign db = depth_of(desc_code);
  assign anc_hit = (anc_code != '0) && (desc_code != '0) && (da <= db) &&
                   ((desc_code >> (db - da)) == anc_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_code   <= '0;
      out_lo     <= '0;
      out_hi     <= '0;
      out_is_anc <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err    <= !mask_ok;
        out_code   <= enc_code;
        out_lo     <= dec_lo;
        out_hi     <= dec_hi;
        out_is_anc <= anc_hit;
      end
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_code) && $stable(out_lo) &&
                   $stable(out_hi) && $stable(out_is_anc) && $stable(out_err)));

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_code == '0 && out_lo == '0 && out_hi == '0));

  // R4
  span_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |->
      (out_lo <= out_hi && $countones(CW'(out_hi ^ out_lo) + CW'(1)) == 1));

  // R5
  code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (out_code != '0));

  // R6
  self_anc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && anc_code == desc_code && anc_code != '0) |=> out_is_anc);

  // R6
  zero_anc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (anc_code == '0 || desc_code == '0)) |=> !out_is_anc);

endmodule

// File: tb/prefix_tree_codec_tb.sv
module prefix_tree_codec_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0, in_mask = '0;
  logic [W:0] anc_code = '0, desc_code = '0;
  logic out_valid, out_err, out_is_anc;
  logic [W:0] out_code;
  logic [W-1:0] out_lo, out_hi;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_tree_codec #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .in_mask(in_mask),
    .anc_code(anc_code), .desc_code(desc_code),
    .out_valid(out_valid), .out_err(out_err), .out_code(out_code),
    .out_lo(out_lo), .out_hi(out_hi), .out_is_anc(out_is_anc)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit legal_mask(input logic [W-1:0] m);
    bit seen_zero = 0;
    for (int j = W-1; j >= 0; j--) begin
      if (!m[j]) seen_zero = 1;
      else if (seen_zero) return 0;
    end
    return 1;
  endfunction

  function automatic int tree_code(input logic [W-1:0] d, input logic [W-1:0] m);
    int c = 1;
    for (int j = W-1; j >= 0; j--)
      if (m[j]) c = c * 2 + int'(d[j]);
    return c;
  endfunction

  function automatic bit is_anc(input int a, input int b);
    int t = b;
    if (a == 0 || b == 0) return 0;
    while (t > a) t = t / 2;
    return t == a;
  endfunction

  task automatic drive(input logic [W-1:0] d, input logic [W-1:0] m,
                       input int a, input int b);
    in_valid  = 1'b1;
    in_data   = d;
    in_mask   = m;
    anc_code  = (W+1)'(a);
    desc_code = (W+1)'(b);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] d, m, lowm, prev_lo;
    int prev_code;
    repeat (3) @(negedge clk);
    // R8
    chk("R8 valid", int'(out_valid), 0);
    chk("R8 code", int'(out_code), 0);
    chk("R8 lo/hi", int'(out_lo) + int'(out_hi), 0);
    chk("R8 err/anc", int'(out_err) + int'(out_is_anc), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R5: every legal rule, junk in don't-care bits
    for (int k = 0; k <= W; k++) begin
      for (int v = 0; v < (1 << k); v++) begin
        m = ~(W'((1 << (W-k)) - 1));
        lowm = ~m;
        d = W'(v << (W-k)) | (W'(v*37 + k*91 + 5) & lowm);
        drive(d, m, 0, 0);
        chk("R7 valid", int'(out_valid), 1);
        chk("R3 no err", int'(out_err), 0);
        chk("R1/R2 code", int'(out_code), tree_code(d, m));
        chk("R5 top bit", int'(out_code >> k), 1);
        chk("R4 lo", int'(out_lo), int'(d & m));
        chk("R4 hi", int'(out_hi), int'(d | lowm));
      end
    end

    // R2: flipping only don't-care bits changes nothing
    drive(8'hA0, 8'hF0, 0, 0);
    prev_code = int'(out_code);
    prev_lo = out_lo;
    drive(8'hAF, 8'hF0, 0, 0);
    chk("R2 code unchanged", int'(out_code), prev_code);
    chk("R2 lo unchanged", int'(out_lo), int'(prev_lo));

    // R4 corners
    drive(8'h5C, 8'hFF, 0, 0);
    chk("R4 full care lo", int'(out_lo), 'h5C);
    chk("R4 full care hi", int'(out_hi), 'h5C);
    drive(8'h77, 8'h00, 0, 0);
    chk("R4 wildcard code", int'(out_code), 1);
    chk("R4 wildcard hi", int'(out_hi), 255);

    // R3: all masks
    for (int mm = 0; mm < 256; mm++) begin
      drive(8'hA5, W'(mm), 0, 0);
      chk("R3 err", int'(out_err), legal_mask(W'(mm)) ? 0 : 1);
      if (!legal_mask(W'(mm))) begin
        chk("R3 code zero", int'(out_code), 0);
        chk("R3 span zero", int'(out_lo) + int'(out_hi), 0);
      end else begin
        chk("R1 code", int'(out_code), tree_code(8'hA5, W'(mm)));
      end
    end

    // R6: shallow codes against every code, both positions
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 512; b++) begin
        drive(8'h00, 8'h00, a, b);
        chk("R6 anc", int'(out_is_anc), int'(is_anc(a, b)));
        drive(8'h00, 8'h00, b, a);
        chk("R6 anc swapped", int'(out_is_anc), int'(is_anc(b, a)));
      end
    end

    // R7: hold when in_valid low
    drive(8'hC3, 8'hF8, 3, 7);
    prev_code = int'(out_code);
    in_valid = 1'b0;
    in_data = 8'h11;
    in_mask = 8'hFF;
    anc_code = '0;
    @(negedge clk);
    chk("R7 valid low", int'(out_valid), 0);
    chk("R7 code held", int'(out_code), prev_code);
    chk("R7 anc held", int'(out_is_anc), 1);
    @(negedge clk);
    chk("R7 code still held", int'(out_code), prev_code);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule